// File: doc/BRIEF.md
# HDLC Frame Receiver with Check-Field Holdback

This block accepts a serial bit stream, one bit per cycle in which a valid strobe is high. It locks onto frame boundaries by spotting the 8-bit flag 0-1-1-1-1-1-1-0. Between two flags it drops the zero that a transmitter inserts after every run of five ones. The recovered bits come out on a serial port with a start marker on the first bit. When the closing flag arrives, the block reports the result of the frame check.

A frame may hold any number of bits, so the receiver cannot tell which bits belong to the 16-bit check field until the closing flag appears. Two small delay lines solve this. A 7-bit pre-stage absorbs the closing flag's own bits: its leading zero and six ones. A 16-bit holdback then keeps the most recent confirmed bits, which are the check-field candidates. A bit is released as payload only once 16 newer confirmed bits stand behind it. The CRC (x^16 + x^12 + x^5 + 1, register preset to all ones, bits fed MSB-first in line order) runs over every confirmed bit, check field included, and a good frame leaves the fixed residue 0x1D0F.

A run of seven ones aborts the current frame. Clock recovery, line decoding and address filtering belong to other blocks.

Top module: `hdlc_frame_rx`

## Requirements
- R1: After reset, and after an abort, the block is in hunt state. In hunt state no output of any kind is produced until the pattern 0,1,1,1,1,1,1,0 has been received on accepted bits.
- R2: Inside a frame, a 0 that follows five consecutive accepted 1s is removed and reaches neither the data output nor the CRC.
- R3: Every de-stuffed frame bit except the last 16 and the closing flag's bits appears exactly once, in arrival order, on `data_bit` with `data_vld` high. The last 16 bits before the closing flag and the closing flag's own bits never appear there.
- R4: If the frame holds at least 32 confirmed bits and the CRC register ends at 0x1D0F, the cycle after the closing flag's last bit shows `frm_end`=1 with `frm_ok`=1.
- R5: A frame of at least 32 confirmed bits whose CRC register does not end at 0x1D0F gives `frm_end`=1 with `frm_ok`=0.
- R6: Payload length need not be a multiple of 8. A frame with any payload bit count is delivered bit-exact.
- R7: Seven consecutive accepted 1s inside a frame pulse `frm_abort` one cycle later, provided at least one bit was confirmed. No `frm_end` follows, and the block returns to hunt state.
- R8: Flags in direct succession, or a frame of 16 or fewer confirmed bits, produce no output at all.
- R9: A frame of 17 to 31 confirmed bits delivers its payload bits, then `frm_end`=1 with `frm_ok`=0.
- R10: The closing flag of one frame also opens the next frame.
- R11: `data_sof` is high together with the first `data_vld` of each frame and at no other time.
- R12: Cycles with `bit_vld` low change no state, whatever the value of `bit_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_in | input | 1 | Received line bit |
| bit_vld | input | 1 | Bit strobe; `bit_in` is taken when high |
| data_bit | output | 1 | De-stuffed payload bit |
| data_vld | output | 1 | `data_bit` is valid this cycle |
| data_sof | output | 1 | First payload bit of a frame |
| frm_end | output | 1 | Closing flag seen for a reportable frame |
| frm_ok | output | 1 | Frame check passed (valid with `frm_end`) |
| frm_abort | output | 1 | Frame dropped on a run of seven ones |

## Verification
The bench builds the block with its default parameters: a six-one flag run, a 16-bit check field and a 32-bit minimum frame. With these defaults, short payloads of 0, 8 and 16 bits land exactly on the silent case, the runt window and the lower good-frame edge. The abort case uses a 40-bit payload, so the pre-stage and the holdback are both full when the abort arrives, and the expected count of released bits (23) is fixed. Gapped strobes with a toggling `bit_in` run alongside odd-length payloads and fully stuffed all-ones payloads.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

   // Classification of one accepted line bit
   typedef enum logic [1:0] {
      SYM_DATA  = 2'd0,
      SYM_STUFF = 2'd1,
      SYM_FLAG  = 2'd2,
      SYM_ABORT = 2'd3
   } sym_e;

   typedef enum logic {
      ST_HUNT  = 1'b0,
      ST_FRAME = 1'b1
   } rx_state_e;

endpackage

// File: rtl/hdlc_bit_classify.sv
module hdlc_bit_classify
   import hdlc_rx_pkg::*;
#(
   parameter int RUN_LEN = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_vld,
   input  logic bit_in,
   output sym_e sym
);
   localparam int OW = $clog2(RUN_LEN + 2);
   localparam logic [OW-1:0] RUN_MAX  = OW'(RUN_LEN + 1);
   localparam logic [OW-1:0] RUN_FULL = OW'(RUN_LEN);
   localparam logic [OW-1:0] RUN_STUF = OW'(RUN_LEN - 1);

   logic [OW-1:0] ones_q;

   initial begin
      assert (RUN_LEN >= 2) else $error("RUN_LEN must be at least 2");
   end

   always_comb begin
      if (bit_in) begin
         sym = (ones_q >= RUN_FULL) ? SYM_ABORT : SYM_DATA;
      end else if (ones_q == RUN_FULL) begin
         sym = SYM_FLAG;
      end else if (ones_q == RUN_STUF) begin
         sym = SYM_STUFF;
      end else begin
         sym = SYM_DATA;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ones_q <= '0;
      end else if (bit_vld) begin
         if (!bit_in)                ones_q <= '0;
         else if (ones_q != RUN_MAX) ones_q <= ones_q + 1'b1;
      end
   end

   // A flag or stuffed zero is always a zero on the line
   assert_zero_kinds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_vld && (sym == SYM_FLAG || sym == SYM_STUFF)) |-> !bit_in);

endmodule

// File: rtl/hdlc_delay_line.sv
module hdlc_delay_line #(
   parameter int DEPTH = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic push,
   input  logic din,
   output logic pop,
   output logic dout
);
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [CW-1:0] FULL = CW'(DEPTH);

   logic [DEPTH-1:0] sr_q;
   logic [CW-1:0]    occ_q;

   initial begin
      assert (DEPTH >= 1) else $error("DEPTH must be at least 1");
   end

   assign pop  = push && !clr && (occ_q == FULL);
   assign dout = sr_q[DEPTH-1];

   generate
      if (DEPTH == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    sr_q <= '0;
            else if (clr)  sr_q <= '0;
            else if (push) sr_q <= din;
         end
      end else begin : g_shift
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    sr_q <= '0;
            else if (clr)  sr_q <= '0;
            else if (push) sr_q <= {sr_q[DEPTH-2:0], din};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      occ_q <= '0;
      else if (clr)                    occ_q <= '0;
      else if (push && occ_q != FULL)  occ_q <= occ_q + 1'b1;
   end

   assert_occ_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      occ_q <= FULL);

   assert_clr_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (occ_q == '0));

endmodule

// File: rtl/hdlc_crc_serial.sv
module hdlc_crc_serial #(
   parameter int             W    = 16,
   parameter logic [W-1:0]   POLY = 16'h1021,
   parameter logic [W-1:0]   INIT = 16'hFFFF
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   input  logic         din,
   output logic [W-1:0] crc
);
   logic fb;

   initial begin
      assert (W >= 2) else $error("W must be at least 2");
   end

   assign fb = crc[W-1] ^ din;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     crc <= INIT;
      else if (clr)   crc <= INIT;
      else if (en)    crc <= {crc[W-2:0], 1'b0} ^ (fb ? POLY : '0);
   end

   assert_hold_when_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !clr) |=> $stable(crc));

endmodule

// File: rtl/hdlc_frame_rx.sv
module hdlc_frame_rx
   import hdlc_rx_pkg::*;
#(
   parameter int                  RUN_LEN        = 6,
   parameter int                  FCS_BITS       = 16,
   parameter int                  MIN_FRAME_BITS = 32,
   parameter int                  CNT_W          = 16,
   parameter logic [FCS_BITS-1:0] CRC_POLY       = 16'h1021,
   parameter logic [FCS_BITS-1:0] CRC_INIT       = 16'hFFFF,
   parameter logic [FCS_BITS-1:0] CRC_RESIDUE    = 16'h1D0F
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_in,
   input  logic bit_vld,
   output logic data_bit,
   output logic data_vld,
   output logic data_sof,
   output logic frm_end,
   output logic frm_ok,
   output logic frm_abort
);
   localparam int PRE_DEPTH = RUN_LEN + 1;
   localparam logic [CNT_W-1:0] FCS_CNT = CNT_W'(FCS_BITS);
   localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(MIN_FRAME_BITS);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   initial begin
      assert (MIN_FRAME_BITS > FCS_BITS) else $error("MIN_FRAME_BITS must exceed FCS_BITS");
      assert ((64'd1 << CNT_W) > 64'(MIN_FRAME_BITS)) else $error("CNT_W too narrow");
   end

   sym_e            sym;
   rx_state_e       state_q;
   logic            in_frame, is_flag, is_abort, pipe_clr, pre_push;
   logic            conf_vld, conf_bit, hold_pop, hold_bit;
   logic [CNT_W-1:0]    nbits_q;
   logic [FCS_BITS-1:0] crc;
   logic            sof_pend_q;

   hdlc_bit_classify #(.RUN_LEN(RUN_LEN)) u_class (
      .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in), .sym(sym)
   );

   assign in_frame = (state_q == ST_FRAME);
   assign is_flag  = bit_vld && (sym == SYM_FLAG);
   assign is_abort = bit_vld && (sym == SYM_ABORT) && in_frame;
   assign pipe_clr = is_flag || is_abort;
   assign pre_push = bit_vld && in_frame && (sym == SYM_DATA);

   // Pre-stage swallows the closing flag's leading zero and its ones
   hdlc_delay_line #(.DEPTH(PRE_DEPTH)) u_pre (
      .clk(clk), .rst_n(rst_n), .clr(pipe_clr), .push(pre_push), .din(bit_in),
      .pop(conf_vld), .dout(conf_bit)
   );

   // Holdback keeps the check-field candidates
   hdlc_delay_line #(.DEPTH(FCS_BITS)) u_hold (
      .clk(clk), .rst_n(rst_n), .clr(pipe_clr), .push(conf_vld), .din(conf_bit),
      .pop(hold_pop), .dout(hold_bit)
   );

   hdlc_crc_serial #(.W(FCS_BITS), .POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
      .clk(clk), .rst_n(rst_n), .clr(pipe_clr), .en(conf_vld), .din(conf_bit), .crc(crc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_HUNT;
         nbits_q    <= '0;
         sof_pend_q <= 1'b0;
      end else begin
         if (is_flag)       state_q <= ST_FRAME;
         else if (is_abort) state_q <= ST_HUNT;

         if (pipe_clr)                          nbits_q <= '0;
         else if (conf_vld && nbits_q != CNT_MAX) nbits_q <= nbits_q + 1'b1;

         if (pipe_clr)      sof_pend_q <= 1'b1;
         else if (hold_pop) sof_pend_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_vld  <= 1'b0;
         data_bit  <= 1'b0;
         data_sof  <= 1'b0;
         frm_end   <= 1'b0;
         frm_ok    <= 1'b0;
         frm_abort <= 1'b0;
      end else begin
         data_vld  <= hold_pop;
         data_bit  <= hold_pop && hold_bit;
         data_sof  <= hold_pop && sof_pend_q;
         frm_end   <= is_flag && in_frame && (nbits_q > FCS_CNT);
         frm_ok    <= is_flag && in_frame && (nbits_q >= MIN_CNT) && (crc == CRC_RESIDUE);
         frm_abort <= is_abort && (nbits_q != '0);
      end
   end

   assert_ok_needs_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
      frm_ok |-> frm_end);

   assert_sof_marks_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
      data_sof |-> data_vld);

   assert_end_without_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
      frm_end |-> !data_vld);

   assert_abort_excludes_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
      frm_abort |-> !frm_end);

   assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bit_vld) |-> !(data_vld || frm_end || frm_abort));

   assert_hunt_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state_q) == ST_HUNT) |-> !(data_vld || frm_end || frm_abort));

endmodule

// File: tb/hdlc_frame_rx_tb.sv
`timescale 1ns/1ps
module hdlc_frame_rx_tb_top;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_in = 1'b0;
   logic bit_vld = 1'b0;
   logic data_bit, data_vld, data_sof, frm_end, frm_ok, frm_abort;

   always #2.5 clk = ~clk;

   hdlc_frame_rx dut_i (
      .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
      .data_bit(data_bit), .data_vld(data_vld), .data_sof(data_sof),
      .frm_end(frm_end), .frm_ok(frm_ok), .frm_abort(frm_abort)
   );

   // codes: 0/1 data bit, +2 when start marker; 4 end bad, 5 end good, 6 abort
   typedef struct {
      int    code;
      string req;
   } exp_t;

   exp_t        expq[$];
   int          checks = 0;
   int          fails  = 0;
   bit          gap_mode = 1'b0;
   bit          finished = 1'b0;
   int          drv_ones = 0;
   logic [15:0] lf = 16'hACE1;
   logic [255:0] fb;

   task automatic expect_item(input int code, input string req);
      exp_t e;
      e.code = code;
      e.req  = req;
      expq.push_back(e);
   endtask

   task automatic cmp(input int act);
      exp_t e;
      checks++;
      if (expq.size() == 0) begin
         fails++;
         $display("FAIL R3/R8 unexpected output: actual %0d expected none", act);
      end else begin
         e = expq.pop_front();
         if (e.code != act) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", e.req, act, e.code);
         end
      end
   endtask

   // Monitor
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (data_vld)  cmp(int'(data_bit) + (data_sof ? 2 : 0));
         if (frm_end)   cmp(4 + int'(frm_ok));
         if (frm_abort) cmp(6);
      end
   end

   task automatic put(input logic b);
      @(negedge clk);
      bit_in  = b;
      bit_vld = 1'b1;
      if (gap_mode) begin
         @(negedge clk);
         bit_vld = 1'b0;
         bit_in  = ~b;
      end
   endtask

   task automatic idle();
      @(negedge clk);
      bit_vld = 1'b0;
   endtask

   task automatic put_stuffed(input logic b);
      put(b);
      if (b) drv_ones++;
      else   drv_ones = 0;
      if (drv_ones == 5) begin
         put(1'b0);
         drv_ones = 0;
      end
   endtask

   task automatic put_flag();
      put(1'b0);
      for (int i = 0; i < 6; i++) put(1'b1);
      put(1'b0);
      drv_ones = 0;
   endtask

   function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic b);
      logic f;
      f = c[15] ^ b;
      return {c[14:0], 1'b0} ^ (f ? 16'h1021 : 16'h0000);
   endfunction

   task automatic build(input int n, input bit all_ones);
      for (int i = 0; i < n; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         fb[i] = all_ones ? 1'b1 : lf[0];
      end
   endtask

   // Sends payload plus check field (no flags); flip<0 means no corruption
   task automatic send_body(input int n, input bit all_ones, input int flip, input string req);
      logic [15:0] c;
      int tot;
      build(n, all_ones);
      c = 16'hFFFF;
      for (int i = 0; i < n; i++) c = crc_upd(c, fb[i]);
      c = ~c;
      if (flip >= 0) fb[flip] = ~fb[flip];
      for (int i = 0; i < n; i++) expect_item(int'(fb[i]) + ((i == 0) ? 2 : 0), req);
      tot = n + 16;
      if (tot > 16) expect_item(((tot >= 32) && (flip < 0)) ? 5 : 4, req);
      for (int i = 0; i < n; i++) put_stuffed(fb[i]);
      for (int j = 15; j >= 0; j--) put_stuffed(c[j]);
   endtask

   // Payload ending in zero, then seven ones
   task automatic send_abort(input int n, input string req);
      build(n, 1'b0);
      fb[n-1] = 1'b0;
      for (int i = 0; i < n - 17; i++) expect_item(int'(fb[i]) + ((i == 0) ? 2 : 0), req);
      expect_item(6, req);
      for (int i = 0; i < n; i++) put_stuffed(fb[i]);
      for (int i = 0; i < 7; i++) put(1'b1);
      drv_ones = 0;
   endtask

   task automatic drain(input string req);
      idle();
      repeat (12) @(negedge clk);
      checks++;
      if (expq.size() != 0) begin
         fails++;
         $display("FAIL %s: outstanding items actual %0d expected 0", req, expq.size());
         expq.delete();
      end
   endtask

   task automatic summary();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin : main
      repeat (4) @(negedge clk);
      // R1: quiet during reset
      checks++;
      if ({data_vld, data_sof, frm_end, frm_ok, frm_abort} != 5'b0) begin
         fails++;
         $display("FAIL R1 reset outputs: actual %b expected 00000",
                  {data_vld, data_sof, frm_end, frm_ok, frm_abort});
      end
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1: bits before any flag are ignored
      put(1); put(0); put(1); put(1); put(0); put(0); put(1); put(0); put(1);
      drain("R1");

      // R3 R4 R11 good frame, then R2 R10 all-ones payload sharing the flag
      put_flag();
      send_body(32, 1'b0, -1, "R3 R4 R11");
      put_flag();
      send_body(24, 1'b1, -1, "R2 R10");
      put_flag();
      drain("R10");

      // R6 R12 odd length with gapped strobes
      gap_mode = 1'b1;
      send_body(21, 1'b0, -1, "R6 R12");
      put_flag();
      gap_mode = 1'b0;
      drain("R12");

      // R5 corrupted payload bit
      send_body(40, 1'b0, 5, "R5");
      put_flag();
      drain("R5");

      // R8 consecutive flags and check-field-only frame
      put_flag();
      put_flag();
      drain("R8");
      send_body(0, 1'b0, -1, "R8");
      put_flag();
      drain("R8");

      // R9 runt frame
      send_body(8, 1'b0, -1, "R9");
      put_flag();
      drain("R9");

      // R7 abort, idle ones in hunt, then minimum-size good frame
      send_abort(40, "R7");
      for (int i = 0; i < 10; i++) put(1'b1);
      drain("R7");
      put_flag();
      send_body(16, 1'b0, -1, "R4 R7");
      put_flag();
      drain("R4");

      summary();
   end

endmodule